// File: doc/BRIEF.md
# Indexed vector element extract unit

This unit pulls one unsigned element out of a 128-bit vector operand and returns it as a zero-extended 64-bit scalar. The element is a byte, a halfword or a word. Its position is a byte offset taken from the low four bits of a general-purpose index operand. The offset is counted either from the most-significant byte of the vector (left-indexed) or from the least-significant byte (right-indexed).

All six operations share one path: the vector is padded, shifted right and masked. Only the shift amount changes with the direction. Bytes of an element that fall outside the vector read as zero. When the vector unit is disabled, no result is produced and a fault flag is raised instead. A valid strobe loads the result and the fault into registers at the next rising clock edge.

Top module: `vec_extract_unit`

## Requirements
- R1: Only bits [3:0] of `idx_in` form the byte offset (0 to 15). Changing any higher bit does not change the result.
- R2: With `dir_left`=0 (right-indexed), the element's least-significant byte is vector byte `offset`, where byte 0 is `vec_in[7:0]`. Each further element byte is the next more-significant vector byte.
- R3: With `dir_left`=1 (left-indexed), the element's most-significant byte is vector byte `offset`, where byte 0 is `vec_in[127:120]`. Each further element byte is the next less-significant vector byte.
- R4: `size_sel` picks the element width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits. The result is zero above the element width.
- R5: Element bytes that lie beyond either end of the vector read as zero, and they keep their place within the element.
- R6: When `unit_en`=0, a strobed operation sets `fault`=1 and `result`=0. When `unit_en`=1, it sets `fault`=0.
- R7: `result` and `fault` update only at a rising clock edge where `in_valid`=1. Otherwise they hold their values.
- R8: While `rst`=1, a rising clock edge clears `result` to 0 and `fault` to 0.
- R9: `size_sel`=3 is reserved. A strobed operation with this value gives `result`=0 and `fault`=0 when the unit is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe that loads a new result |
| vec_in | input | 128 | Vector operand |
| idx_in | input | 64 | Index operand; low 4 bits are the byte offset |
| size_sel | input | 2 | Element size: 0 byte, 1 halfword, 2 word, 3 reserved |
| dir_left | input | 1 | 1 counts the offset from the most-significant byte, 0 from the least-significant byte |
| unit_en | input | 1 | Vector unit enabled |
| result | output | 64 | Zero-extended element |
| fault | output | 1 | Vector-unavailable fault |

## Verification
Both `result` and `fault` come from one register stage. They are due at the first rising edge after `in_valid` is seen high, and they stay put until the next strobe. The bench drives every operation on a falling edge and reads the outputs on the following falling edge, with exactly one rising edge in between. The hold check leaves the strobe low for several edges while the operands change, then reads the outputs again. The reset checks read the outputs on the falling edge after a reset edge.

// File: rtl/vec_extract_unit.sv
module vec_extract_unit #(
  parameter int VEC_W = 128,
  parameter int IDX_W = 64,
  parameter int RES_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] vec_in,
  input  logic [IDX_W-1:0] idx_in,
  input  logic [1:0]       size_sel,
  input  logic             dir_left,
  input  logic             unit_en,
  output logic [RES_W-1:0] result,
  output logic             fault
);
  localparam int OFF_W    = $clog2(VEC_W / 8);
  localparam int PAD_W    = 32;
  localparam int PADDED_W = VEC_W + PAD_W;
  localparam int SH_W     = $clog2(PADDED_W) + 1;

  logic [OFF_W-1:0]    off;
  logic [SH_W-1:0]     off_bits;
  logic [SH_W-1:0]     size_bits;
  logic [SH_W-1:0]     sh;
  logic [PADDED_W-1:0] shifted;
  logic [RES_W-1:0]    elem;
  logic                unused_idx_hi;
  logic                unused_shift_hi;

  assign off           = idx_in[OFF_W-1:0];
  assign unused_idx_hi = ^idx_in[IDX_W-1:OFF_W];
  assign off_bits      = SH_W'(off) << 3;

  always_comb begin
    case (size_sel)
      2'd0:    size_bits = SH_W'(8);
      2'd1:    size_bits = SH_W'(16);
      default: size_bits = SH_W'(32);
    endcase
  end

  // Padding below the vector keeps the left-indexed shift non-negative.
  assign sh = dir_left ? SH_W'(PADDED_W) - off_bits - size_bits
                       : SH_W'(PAD_W) + off_bits;

  assign shifted         = {vec_in, {PAD_W{1'b0}}} >> sh;
  assign unused_shift_hi = ^shifted[PADDED_W-1:32];

  always_comb begin
    case (size_sel)
      2'd0:    elem = RES_W'(shifted[7:0]);
      2'd1:    elem = RES_W'(shifted[15:0]);
      2'd2:    elem = RES_W'(shifted[31:0]);
      default: elem = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      fault  <= 1'b0;
    end else if (in_valid) begin
      result <= unit_en ? elem : '0;
      fault  <= ~unit_en;
    end
  end
endmodule

// File: rtl/vec_extract_unit_chk.sv
module vec_extract_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [1:0]  size_sel,
  input logic        unit_en,
  input logic [63:0] result,
  input logic        fault
);
  a_r8_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (result == 64'd0 && !fault));

  a_r7_hold_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(fault)));

  a_r6_fault_disabled: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !unit_en) |=> (fault && result == 64'd0));

  a_r6_no_fault_enabled: assert property (@(posedge clk) disable iff (rst)
    (in_valid && unit_en) |=> !fault);

  a_r4_byte_width: assert property (@(posedge clk) disable iff (rst)
    (in_valid && unit_en && size_sel == 2'd0) |=> (result[63:8] == 56'd0));

  a_r4_half_width: assert property (@(posedge clk) disable iff (rst)
    (in_valid && unit_en && size_sel == 2'd1) |=> (result[63:16] == 48'd0));

  a_r4_word_width: assert property (@(posedge clk) disable iff (rst)
    (in_valid && unit_en && size_sel == 2'd2) |=> (result[63:32] == 32'd0));

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && unit_en && size_sel == 2'd3) |=> (result == 64'd0 && !fault));
endmodule

bind vec_extract_unit vec_extract_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .size_sel(size_sel),
  .unit_en(unit_en), .result(result), .fault(fault)
);

// File: tb/vec_extract_unit_bench.sv
`timescale 1ns/1ps
module vec_extract_unit_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] vec_in = '0;
  logic [63:0]  idx_in = '0;
  logic [1:0]   size_sel = '0;
  logic         dir_left = 1'b0;
  logic         unit_en = 1'b0;
  logic [63:0]  result;
  logic         fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  vec_extract_unit u_vec_extract_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .vec_in(vec_in), .idx_in(idx_in),
    .size_sel(size_sel), .dir_left(dir_left), .unit_en(unit_en),
    .result(result), .fault(fault)
  );

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [63:0] idx;
    logic [1:0]  sz;
    logic        left;
    logic        en;
    logic [63:0] exp_res;
    logic        exp_fault;
  } vec_t;

  localparam logic [127:0] V0 = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{64'd3,                  2'd0, 1'b1, 1'b1, 64'h33,         1'b0},
    '{64'hFFFF_FFFF_FFFF_FFF2, 2'd1, 1'b0, 1'b1, 64'hCCDD,       1'b0},
    '{64'd5,                  2'd2, 1'b1, 1'b1, 64'h5566_7788,  1'b0},
    '{64'd15,                 2'd2, 1'b1, 1'b1, 64'hFF00_0000,  1'b0},
    '{64'd14,                 2'd2, 1'b0, 1'b1, 64'h0000_0011,  1'b0},
    '{64'd4,                  2'd1, 1'b0, 1'b0, 64'h0,          1'b1},
    '{64'd6,                  2'd3, 1'b1, 1'b1, 64'h0,          1'b0}
  };

  function automatic logic [63:0] model(input logic [127:0] v, input int off,
                                        input int sz, input bit left);
    logic [7:0] b [16];
    logic [63:0] r = '0;
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
    for (int i = 0; i < 16; i++) b[i] = v[127 - 8*i -: 8];
    for (int j = 0; j < n; j++) begin
      int p = off + j;
      if (left) r = (r << 8) | ((p < 16) ? 64'(b[p]) : 64'd0);
      else      r = r | (((p < 16) ? 64'(b[15 - p]) : 64'd0) << (8*j));
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] er, input logic ef);
    checks++;
    if (result !== er || fault !== ef) begin
      errors++;
      $display("FAIL %s result=%h fault=%b expected result=%h fault=%b",
               tag, result, fault, er, ef);
    end
  endtask

  task automatic apply(input logic [127:0] v, input logic [63:0] idx,
                       input logic [1:0] sz, input logic left, input logic en);
    vec_in = v; idx_in = idx; size_sel = sz; dir_left = left; unit_en = en;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] v1;
    logic [63:0]  held;
    v1 = 128'hA55A_0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2;
    @(negedge clk); @(negedge clk);
    check("R8 reset state", 64'd0, 1'b0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      apply(V0, TBL[k].idx, TBL[k].sz, TBL[k].left, TBL[k].en);
      check($sformatf("R1 R2 R3 R4 R5 R6 R9 table entry %0d", k),
            TBL[k].exp_res, TBL[k].exp_fault);
    end

    for (int vs = 0; vs < 2; vs++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 3; s++)
          for (int o = 0; o < 16; o++) begin
            logic [127:0] vv = vs ? v1 : V0;
            apply(vv, {60'hABCDE12_3456789, 4'(o)}, 2'(s), d[0], 1'b1);
            check($sformatf("%s R4 R5 sweep left=%0d size=%0d off=%0d",
                            d ? "R3" : "R2", d, s, o),
                  model(vv, o, s, d[0]), 1'b0);
          end

    apply(V0, 64'h1, 2'd1, 1'b1, 1'b1);
    check("R1 offset 1 upper bits clear", 64'h1122, 1'b0);
    apply(V0, 64'h8000_0000_0000_0011, 2'd1, 1'b1, 1'b1);
    check("R1 offset 1 upper bits set", 64'h1122, 1'b0);

    held = result;
    vec_in = v1; idx_in = 64'd9; size_sel = 2'd2; unit_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 hold without strobe", held, 1'b0);

    apply(V0, 64'd0, 2'd0, 1'b0, 1'b0);
    check("R6 disabled unit faults", 64'd0, 1'b1);
    apply(V0, 64'd0, 2'd0, 1'b0, 1'b1);
    check("R6 enabled unit clears fault", 64'hFF, 1'b0);

    apply(V0, 64'd0, 2'd3, 1'b0, 1'b1);
    check("R9 reserved size right", 64'd0, 1'b0);

    apply(V0, 64'd2, 2'd2, 1'b1, 1'b1);
    check("R3 word before reset", 64'h2233_4455, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset clears result", 64'd0, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule